// File: doc/BRIEF.md
# Display Row and Frame Timing Generator

This block turns an operating clock into the row and frame timing of a dot-matrix display scanner. The operating clock arrives as a single-cycle tick from one of two sources: an on-chip oscillator or an external clock pin, picked by a static strap. The selected ticks are divided by a programmable ratio to form the display clock. Each display row lasts a programmable number of display clocks, split into a first phase, a second phase and a fixed settle portion of 50 display clocks. Rows are counted from zero up to a programmed last-row value and then wrap, which closes one frame.

The block gives the current row index, one indicator per phase, a one-cycle row strobe at the start of every row and a one-cycle frame sync at the start of every frame. The host uses the frame sync to time its display-memory writes so that a frame is never shown half old and half new. The divide ratio, both phase lengths and the last-row value come from configuration inputs. They are sampled only at a frame boundary, so the frame in progress keeps its timing whatever the inputs do.

The row sequencer is a three-state machine. ST_PH1 drives the first phase and moves to ST_PH2 when its count expires. ST_PH2 drives the second phase and moves to ST_HOLD when its count expires. ST_HOLD covers the settle portion and moves back to ST_PH1 after 50 display clocks, stepping the row index. That last move either advances to the next row (row step) or, from the last row, returns to row 0 (frame wrap).

Top module: `dtg_timing_gen`

## Requirements
- R1: When `osc_sel` is 1 the operating ticks are taken from `int_osc_tick`. When it is 0 they are taken from `ext_clk_tick`. The unselected input has no effect.
- R2: One display clock spans D operating ticks, where D = `div_cfg` + 1 (1 to 16).
- R3: Each row runs phase 1 (`ph1_active`=1) for P1 display clocks, then phase 2 (`ph2_active`=1) for P2 display clocks, then 50 display clocks with both indicators 0. P1 and P2 are the programmed lengths, and a programmed 0 counts as 1.
- R4: The row index counts 0, 1, … up to `mux_cfg` and then returns to 0. A `mux_cfg` of 0 gives a frame of a single row.
- R5: `row_strobe` is high for exactly one cycle at the start of every row, on the first cycle in which `row_idx` shows the new row. `row_idx` changes on no other cycle.
- R6: `frame_sync` is high for exactly one cycle, together with `row_strobe`, when `row_idx` returns to 0. It is never high at any other time.
- R7: The configuration inputs are sampled only at a frame wrap. Changes made during a frame have no effect until the frame that starts with the next `frame_sync`.
- R8: While `srst` is high, `row_idx` is 0, `ph1_active` is 1, `ph2_active`, `row_strobe` and `frame_sync` are 0, and all counters clear. After reset the active settings are D=1, P1=2, P2=2 and last row 38 (a 54-clock row, 39 rows) until the first frame wrap, whatever the inputs hold.
- R9: `ph1_active` and `ph2_active` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| osc_sel | input | 1 | Static strap: 1 selects the on-chip oscillator ticks, 0 selects the external ticks |
| int_osc_tick | input | 1 | One-cycle tick per on-chip oscillator period |
| ext_clk_tick | input | 1 | One-cycle tick per external clock period |
| div_cfg | input | 4 | Divide ratio minus one |
| ph1_cfg | input | 4 | Phase 1 length in display clocks (0 counts as 1) |
| ph2_cfg | input | 4 | Phase 2 length in display clocks (0 counts as 1) |
| mux_cfg | input | 6 | Index of the last row of a frame |
| row_idx | output | 6 | Current row index |
| ph1_active | output | 1 | High during phase 1 of the row |
| ph2_active | output | 1 | High during phase 2 of the row |
| row_strobe | output | 1 | One-cycle pulse at the start of each row |
| frame_sync | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The assertions check on every cycle the properties that involve no counting. They check that the phase indicators are exclusive, that phase 1 can only fall into phase 2 and phase 2 only into the settle portion, that the row index moves only with a strobe and then by exactly one or back to zero, that it never passes the active last-row value, and that the frame sync comes only with a strobe on row 0. The bench scenarios show the properties that involve durations and history. These are the length of each phase in system cycles for a given divide ratio and tick source, the number of rows per frame, the defaults holding through the first frame, and the rule that a setting written mid-frame only appears in the frame that follows.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Field widths of the configuration inputs
    localparam int DIV_W    = 4;
    localparam int PH_W     = 4;
    localparam int ROW_W    = 6;
    // Fixed settle portion of every row, in display clocks
    localparam int HOLD_LEN = 50;

    // Counter wide enough for the longest of phase 1, phase 2 and settle
    localparam int PH_MAX   = (1 << PH_W) - 1;
    localparam int LEN_MAX  = (HOLD_LEN > PH_MAX) ? HOLD_LEN : PH_MAX;
    localparam int CNT_W    = $clog2(LEN_MAX + 1);

    // Settings after reset
    localparam int DEF_DIV  = 0;
    localparam int DEF_PH1  = 2;
    localparam int DEF_PH2  = 2;
    localparam int DEF_MUX  = 38;

    typedef enum logic [1:0] {
        ST_PH1  = 2'd0,
        ST_PH2  = 2'd1,
        ST_HOLD = 2'd2
    } row_state_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PH_W-1:0]  ph1;
        logic [PH_W-1:0]  ph2;
        logic [ROW_W-1:0] mux;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        div: DIV_W'(DEF_DIV),
        ph1: PH_W'(DEF_PH1),
        ph2: PH_W'(DEF_PH2),
        mux: ROW_W'(DEF_MUX)
    };

endpackage

// File: rtl/dtg_tick_div.sv
module dtg_tick_div
    import dtg_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               srst,
    input  logic               osc_sel,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [DIV_W-1:0]   div_ratio,
    output logic               dclk_en
);

    // src_tick[1] is the on-chip oscillator, src_tick[0] the external pin.
    logic op_tick;

    generate
        if (NUM_SRC == 1) begin : g_single
            assign op_tick = src_tick[0];
        end else begin : g_select
            assign op_tick = osc_sel ? src_tick[1] : src_tick[0];
        end
    endgenerate

    logic [DIV_W-1:0] tick_cnt;

    // The compare uses >= so that a smaller ratio loaded at a frame
    // boundary still ends the current count at once.
    always_ff @(posedge clk) begin
        if (srst) begin
            tick_cnt <= '0;
            dclk_en  <= 1'b0;
        end else begin
            dclk_en <= 1'b0;
            if (op_tick) begin
                if (tick_cnt >= div_ratio) begin
                    tick_cnt <= '0;
                    dclk_en  <= 1'b1;
                end else begin
                    tick_cnt <= tick_cnt + DIV_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/dtg_cfg_shadow.sv
module dtg_cfg_shadow
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             srst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic [PH_W-1:0]  ph1_in,
    input  logic [PH_W-1:0]  ph2_in,
    input  logic [ROW_W-1:0] mux_in,
    output cfg_t             cfg_act,
    output cfg_t             cfg_look
);

    logic [PH_W-1:0] ph_raw [2];
    logic [PH_W-1:0] ph_fix [2];
    cfg_t            cfg_in;

    assign ph_raw[0] = ph1_in;
    assign ph_raw[1] = ph2_in;

    // A zero phase length is stretched to one display clock.
    generate
        for (genvar i = 0; i < 2; i++) begin : g_clamp
            assign ph_fix[i] = (ph_raw[i] == '0) ? PH_W'(1) : ph_raw[i];
        end
    endgenerate

    always_comb begin
        cfg_in.div = div_in;
        cfg_in.ph1 = ph_fix[0];
        cfg_in.ph2 = ph_fix[1];
        cfg_in.mux = mux_in;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            cfg_act <= CFG_RESET;
        end else if (load) begin
            cfg_act <= cfg_in;
        end
    end

    // The divider sees the incoming settings on the boundary cycle, so its
    // first period of the new frame already uses the new ratio.
    assign cfg_look = load ? cfg_in : cfg_act;

endmodule

// File: rtl/dtg_row_fsm.sv
module dtg_row_fsm
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             srst,
    input  logic             dclk_en,
    input  logic [PH_W-1:0]  ph1_len,
    input  logic [PH_W-1:0]  ph2_len,
    input  logic [ROW_W-1:0] mux_last,
    output logic [ROW_W-1:0] row_idx,
    output logic             ph1_active,
    output logic             ph2_active,
    output logic             row_strobe,
    output logic             frame_sync,
    output logic             frame_wrap
);

    row_state_t       state, state_nx;
    logic [CNT_W-1:0] len_cnt;
    logic [CNT_W-1:0] cur_len;
    logic             len_done;
    logic             row_last;
    logic             row_done;

    // Length of the state now running, and the state that follows it
    always_comb begin
        cur_len  = CNT_W'(HOLD_LEN);
        state_nx = ST_PH1;
        unique case (state)
            ST_PH1: begin
                cur_len  = CNT_W'(ph1_len);
                state_nx = ST_PH2;
            end
            ST_PH2: begin
                cur_len  = CNT_W'(ph2_len);
                state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                cur_len  = CNT_W'(HOLD_LEN);
                state_nx = ST_PH1;
            end
            default: begin
                cur_len  = CNT_W'(1);
                state_nx = ST_PH1;
            end
        endcase
    end

    assign len_done   = dclk_en && (len_cnt == (cur_len - CNT_W'(1)));
    assign row_done   = len_done && (state == ST_HOLD);
    assign row_last   = (row_idx == mux_last);
    assign frame_wrap = row_done && row_last;

    // State register, phase counter and row counter
    always_ff @(posedge clk) begin
        if (srst) begin
            state   <= ST_PH1;
            len_cnt <= '0;
            row_idx <= '0;
        end else if (dclk_en) begin
            if (len_done) begin
                state   <= state_nx;
                len_cnt <= '0;
                if (state == ST_HOLD) begin
                    row_idx <= row_last ? '0 : row_idx + ROW_W'(1);
                end
            end else begin
                len_cnt <= len_cnt + CNT_W'(1);
            end
        end
    end

    // Pulse outputs, registered so they line up with the new row index
    always_ff @(posedge clk) begin
        if (srst) begin
            row_strobe <= 1'b0;
            frame_sync <= 1'b0;
        end else begin
            row_strobe <= row_done;
            frame_sync <= frame_wrap;
        end
    end

    assign ph1_active = (state == ST_PH1);
    assign ph2_active = (state == ST_PH2);

endmodule

// File: rtl/dtg_timing_gen.sv
module dtg_timing_gen
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             srst,
    input  logic             osc_sel,
    input  logic             int_osc_tick,
    input  logic             ext_clk_tick,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic [PH_W-1:0]  ph1_cfg,
    input  logic [PH_W-1:0]  ph2_cfg,
    input  logic [ROW_W-1:0] mux_cfg,
    output logic [ROW_W-1:0] row_idx,
    output logic             ph1_active,
    output logic             ph2_active,
    output logic             row_strobe,
    output logic             frame_sync
);

    cfg_t cfg_act;
    cfg_t cfg_look;
    logic dclk_en;
    logic frame_wrap;

    dtg_cfg_shadow u_shadow (
        .clk      (clk),
        .srst     (srst),
        .load     (frame_wrap),
        .div_in   (div_cfg),
        .ph1_in   (ph1_cfg),
        .ph2_in   (ph2_cfg),
        .mux_in   (mux_cfg),
        .cfg_act  (cfg_act),
        .cfg_look (cfg_look)
    );

    dtg_tick_div #(.NUM_SRC(2)) u_div (
        .clk       (clk),
        .srst      (srst),
        .osc_sel   (osc_sel),
        .src_tick  ({int_osc_tick, ext_clk_tick}),
        .div_ratio (cfg_look.div),
        .dclk_en   (dclk_en)
    );

    dtg_row_fsm u_rows (
        .clk        (clk),
        .srst       (srst),
        .dclk_en    (dclk_en),
        .ph1_len    (cfg_act.ph1),
        .ph2_len    (cfg_act.ph2),
        .mux_last   (cfg_act.mux),
        .row_idx    (row_idx),
        .ph1_active (ph1_active),
        .ph2_active (ph2_active),
        .row_strobe (row_strobe),
        .frame_sync (frame_sync),
        .frame_wrap (frame_wrap)
    );

endmodule

// File: rtl/dtg_timing_gen_chk.sv
module dtg_timing_gen_chk
    import dtg_pkg::*;
(
    input logic             clk,
    input logic             srst,
    input logic             ph1,
    input logic             ph2,
    input logic             strobe,
    input logic             fsync,
    input logic [ROW_W-1:0] row_idx,
    input logic [ROW_W-1:0] mux_last
);

    assert_phase_excl_R9: assert property (@(posedge clk) disable iff (srst)
        !(ph1 && ph2));

    assert_ph1_exit_R3: assert property (@(posedge clk) disable iff (srst)
        $fell(ph1) |-> ph2);

    assert_ph2_exit_R3: assert property (@(posedge clk) disable iff (srst)
        $fell(ph2) |-> !ph1);

    assert_row_start_R5: assert property (@(posedge clk) disable iff (srst)
        $rose(ph1) |-> strobe);

    assert_strobe_ph1_R5: assert property (@(posedge clk) disable iff (srst)
        strobe |-> ph1);

    assert_row_still_R5: assert property (@(posedge clk) disable iff (srst)
        !strobe |-> $stable(row_idx));

    assert_row_step_R4: assert property (@(posedge clk) disable iff (srst)
        (strobe && (row_idx != '0)) |-> (row_idx == $past(row_idx) + ROW_W'(1)));

    assert_row_bound_R4: assert property (@(posedge clk) disable iff (srst)
        row_idx <= mux_last);

    assert_fsync_row0_R6: assert property (@(posedge clk) disable iff (srst)
        fsync |-> (strobe && (row_idx == '0)));

endmodule

bind dtg_timing_gen dtg_timing_gen_chk u_chk (
    .clk      (clk),
    .srst     (srst),
    .ph1      (ph1_active),
    .ph2      (ph2_active),
    .strobe   (row_strobe),
    .fsync    (frame_sync),
    .row_idx  (row_idx),
    .mux_last (cfg_act.mux)
);

// File: tb/dtg_timing_gen_test.sv
module dtg_timing_gen_test;

    localparam int HOLD = 50;
    localparam int EXT_PER = 3;
    localparam int GUARD = 150000;

    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       osc_sel = 1'b1;
    logic       int_osc_tick = 1'b1;
    logic       ext_clk_tick;
    logic [3:0] div_cfg = '0;
    logic [3:0] ph1_cfg = '0;
    logic [3:0] ph2_cfg = '0;
    logic [5:0] mux_cfg = '0;
    logic [5:0] row_idx;
    logic       ph1_active, ph2_active, row_strobe, frame_sync;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int ext_cnt = 0;

    always #5 clk = ~clk;

    always @(negedge clk) ext_cnt <= (ext_cnt == EXT_PER - 1) ? 0 : ext_cnt + 1;
    assign ext_clk_tick = (ext_cnt == EXT_PER - 1);

    dtg_timing_gen uut (
        .clk(clk), .srst(srst), .osc_sel(osc_sel),
        .int_osc_tick(int_osc_tick), .ext_clk_tick(ext_clk_tick),
        .div_cfg(div_cfg), .ph1_cfg(ph1_cfg), .ph2_cfg(ph2_cfg), .mux_cfg(mux_cfg),
        .row_idx(row_idx), .ph1_active(ph1_active), .ph2_active(ph2_active),
        .row_strobe(row_strobe), .frame_sync(frame_sync)
    );

    function automatic int eff_len(input int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int dclk_cycles(input int div, input int per);
        return (div + 1) * per;
    endfunction

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int d, input int p1, input int p2, input int m);
        div_cfg = 4'(d);
        ph1_cfg = 4'(p1);
        ph2_cfg = 4'(p2);
        mux_cfg = 6'(m);
    endtask

    task automatic wait_strobe();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!row_strobe && g < GUARD);
        if (!row_strobe) check_eq("R5", "strobe never seen", 0, 1);
    endtask

    task automatic skip_to_fsync();
        int g = 0;
        do begin
            wait_strobe();
            g++;
        end while (!frame_sync && g < 100);
    endtask

    // Entered on the negedge where row_strobe marks row first_row.
    // Leaves on the negedge where the following row starts.
    task automatic measure_rows(input int first_row, input int last_row, input int d,
                                input int p1, input int p2, input int per, input string tag);
        int u;
        u = dclk_cycles(d, per);
        for (int r = first_row; r <= last_row; r++) begin
            int n1 = 0, n2 = 0, nh = 0, nb = 0, g = 0;
            check_eq("R5", {tag, " row index at strobe"}, int'(row_idx), r);
            do begin
                if (ph1_active && ph2_active) nb++;
                if (ph1_active) n1++;
                else if (ph2_active) n2++;
                else nh++;
                @(negedge clk);
                g++;
            end while (!row_strobe && g < GUARD);
            check_eq("R3", {tag, " phase 1 cycles (R2 ratio)"}, n1, eff_len(p1) * u);
            check_eq("R3", {tag, " phase 2 cycles"}, n2, eff_len(p2) * u);
            check_eq("R2", {tag, " settle cycles"}, nh, HOLD * u);
            check_eq("R9", {tag, " both phases high"}, nb, 0);
            check_eq("R6", {tag, " frame sync at next strobe"}, int'(frame_sync),
                     (r == last_row) ? 1 : 0);
        end
        check_eq("R4", {tag, " row after wrap"}, int'(row_idx), (last_row < 64 && frame_sync) ? 0 : last_row + 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #1900000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int cd, c1, c2, cm;
        void'($urandom(32'd20240611));

        // R8: reset state with non-default inputs present
        set_cfg(1, 5, 3, 4);
        repeat (5) @(negedge clk);
        check_eq("R8", "row at reset", int'(row_idx), 0);
        check_eq("R8", "phase 1 at reset", int'(ph1_active), 1);
        check_eq("R8", "phase 2 at reset", int'(ph2_active), 0);
        check_eq("R8", "strobe at reset", int'(row_strobe), 0);
        check_eq("R8", "frame sync at reset", int'(frame_sync), 0);
        srst = 1'b0;

        // R8/R7: first frame runs on defaults, inputs ignored
        wait_strobe();
        measure_rows(1, 38, 0, 2, 2, 1, "R8 default frame");
        // R7: settings written before the wrap now in force
        measure_rows(0, 4, 1, 5, 3, 1, "R7 first loaded frame");

        // R7: mid-frame change does not touch the running frame
        set_cfg(0, 0, 15, 0);
        measure_rows(0, 4, 1, 5, 3, 1, "R7 unchanged frame");
        // R4/R3: single-row frames, zero phase stretched to one
        measure_rows(0, 0, 0, 0, 15, 1, "R4 single row");
        set_cfg(15, 1, 1, 1);
        measure_rows(0, 0, 0, 0, 15, 1, "R4 single row repeat");
        // R2: largest divide ratio
        measure_rows(0, 1, 15, 1, 1, 1, "R2 divide by 16");

        // R1: external source, three system cycles per tick
        osc_sel = 1'b0;
        set_cfg(0, 2, 3, 2);
        skip_to_fsync();
        measure_rows(0, 2, 0, 2, 3, EXT_PER, "R1 external source");

        // R1: back to the on-chip source, R4 largest row count
        osc_sel = 1'b1;
        set_cfg(0, 2, 2, 63);
        skip_to_fsync();
        cd = 0; c1 = 2; c2 = 2; cm = 63;
        for (int i = 0; i < 7; i++) begin
            int nd, n1, n2, nm;
            nd = int'($urandom % 4);
            n1 = int'($urandom % 16);
            n2 = int'($urandom % 16);
            nm = int'($urandom % 8);
            set_cfg(nd, n1, n2, nm);
            measure_rows(0, cm, cd, c1, c2, 1, "R7 random sequence");
            cd = nd; c1 = n1; c2 = n2; cm = nm;
        end
        measure_rows(0, cm, cd, c1, c2, 1, "R3 random last");

        done = 1;
        summary();
        $finish;
    end

endmodule